// File: doc/BRIEF.md
# SIMT Divergence Reconvergence Stack

This block tracks control flow for a single warp of threads that share one instruction stream. It holds a small stack of records. Each record has three fields: the PC where its threads rejoin, the PC they fetch next, and a bit mask of the threads it covers. The top record supplies the warp's fetch PC and active mask. A plain advance rewrites the fetch PC of the top record. A resolved branch whose active threads all agree does the same.

When the active threads split on a branch, the top record is parked at the rejoin PC supplied with the branch. A record is then pushed for each path, holding that path's threads. The fall-through record is pushed first and the taken record last, so the taken side runs first and the other side runs after it. When the top record's fetch PC is written to its own rejoin PC, that record is popped in the same cycle, and the wider mask below becomes visible. The bottom record starts with every thread active and an all-ones rejoin value, so it is never popped.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset, the outputs show PC `START_PC`, an all-ones mask, depth 0 and overflow clear.
- R2: An advance writes `adv_pc` into the top record's fetch PC, leaving mask and depth unchanged, unless it pops (R5, R6).
- R3: On a branch, the effective taken mask is the taken mask ANDed with the active mask. If it is all zeros, the fetch PC becomes the fall-through PC. If it equals the active mask, the fetch PC becomes the target. No record is pushed in either case.
- R4: On a divergent branch, the top record's fetch PC becomes the rejoin PC and depth grows by 2. The next output is the target PC with the taken threads.
- R5: When the top path record's new fetch PC equals its rejoin PC, it is popped. The sibling path then shows with its own mask.
- R6: When the last path record pops, the parked record shows the rejoin PC with the full mask it had before the split.
- R7: Taken-mask bits of inactive threads have no effect on the branch outcome.
- R8: When a branch and an advance arrive in the same cycle, the branch wins and the advance is dropped.
- R9: On a divergent branch, a path whose PC equals the rejoin PC gets no record.
- R10: A divergent branch whose rejoin PC equals the current top record's rejoin PC replaces that record with its path records instead of parking it.
- R11: A divergent branch that would need more than `DEPTH` records in total sets a sticky overflow flag and leaves the stack unchanged.
- R12: The bottom record is never popped, even if an advance writes the all-ones value.
- R13: With no branch and no advance, all outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | A resolved branch is presented this cycle |
| br_taken | input | THREADS | Per-thread taken bits (bit i is thread i) |
| br_target | input | PC_W | Taken target PC |
| br_fall | input | PC_W | Fall-through PC |
| br_reconv | input | PC_W | Rejoin PC of the branch |
| adv_valid | input | 1 | Non-branch PC advance this cycle |
| adv_pc | input | PC_W | New fetch PC for the advance |
| cur_pc | output | PC_W | Fetch PC of the top record |
| cur_mask | output | THREADS | Active mask of the top record |
| depth | output | $clog2(DEPTH) | Index of the top record (0 means bottom only) |
| overflow | output | 1 | Sticky stack overflow flag |

## Verification
The bench builds the block with 4 threads, a stack of 4 records and 8-bit PCs. With only 4 records, two nested divergent branches are enough to reach the overflow path. With 8-bit PCs, the all-ones sentinel can be written to the bottom record to show that it does not pop. The random phase draws targets, fall-through PCs and rejoin PCs from only eight values. Pops, empty paths and rejoin-PC merges therefore happen often, and every cycle is compared with a queue-based model.

// File: rtl/simt_stack_pkg.sv
package simt_stack_pkg;
  typedef enum logic [1:0] {
    OP_IDLE    = 2'd0,
    OP_ADV     = 2'd1,
    OP_UNIFORM = 2'd2,
    OP_SPLIT   = 2'd3
  } stk_op_e;
endpackage

// File: rtl/simt_branch_classify.sv
module simt_branch_classify
  import simt_stack_pkg::*;
#(
  parameter int THREADS = 32,
  parameter int PC_W    = 32
) (
  input  logic               br_valid,
  input  logic [THREADS-1:0] br_taken,
  input  logic [PC_W-1:0]    br_target,
  input  logic [PC_W-1:0]    br_fall,
  input  logic [PC_W-1:0]    br_reconv,
  input  logic               adv_valid,
  input  logic [PC_W-1:0]    adv_pc,
  input  logic [THREADS-1:0] top_mask,
  output stk_op_e            op,
  output logic [PC_W-1:0]    new_pc,
  output logic [THREADS-1:0] taken_mask,
  output logic [THREADS-1:0] fall_mask,
  output logic               push_fall,
  output logic               push_taken
);
  always_comb begin
    taken_mask = br_taken & top_mask;
    fall_mask  = top_mask & ~taken_mask;
    push_fall  = (br_fall != br_reconv);
    push_taken = (br_target != br_reconv);
    op         = OP_IDLE;
    new_pc     = adv_pc;
    if (br_valid) begin
      if (taken_mask == '0) begin
        op     = OP_UNIFORM;
        new_pc = br_fall;
      end else if (fall_mask == '0) begin
        op     = OP_UNIFORM;
        new_pc = br_target;
      end else begin
        op     = OP_SPLIT;
        new_pc = br_reconv;
      end
    end else if (adv_valid) begin
      op = OP_ADV;
    end
  end
endmodule

// File: rtl/simt_stack_store.sv
module simt_stack_store #(
  parameter int              THREADS  = 32,
  parameter int              PC_W     = 32,
  parameter int              DEPTH    = 8,
  parameter logic [PC_W-1:0] START_PC = '0,
  localparam int             SP_W     = $clog2(DEPTH),
  localparam int             NWP      = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [SP_W-1:0]                rd_idx,
  output logic [PC_W-1:0]                rd_rc,
  output logic [PC_W-1:0]                rd_npc,
  output logic [THREADS-1:0]             rd_mask,
  input  logic [NWP-1:0]                 we,
  input  logic [NWP-1:0][SP_W-1:0]       wa,
  input  logic [NWP-1:0][PC_W-1:0]       w_rc,
  input  logic [NWP-1:0][PC_W-1:0]       w_npc,
  input  logic [NWP-1:0][THREADS-1:0]    w_mask
);
  logic [DEPTH-1:0][PC_W-1:0]    rc_q;
  logic [DEPTH-1:0][PC_W-1:0]    npc_q;
  logic [DEPTH-1:0][THREADS-1:0] msk_q;

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic               en;
    logic [PC_W-1:0]    rc_d;
    logic [PC_W-1:0]    npc_d;
    logic [THREADS-1:0] msk_d;

    always_comb begin
      en    = 1'b0;
      rc_d  = rc_q[e];
      npc_d = npc_q[e];
      msk_d = msk_q[e];
      for (int p = 0; p < NWP; p++) begin
        if (we[p] && (wa[p] == SP_W'(e))) begin
          en    = 1'b1;
          rc_d  = w_rc[p];
          npc_d = w_npc[p];
          msk_d = w_mask[p];
        end
      end
    end

    if (e == 0) begin : g_bottom
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rc_q[e]  <= '1;
          npc_q[e] <= START_PC;
          msk_q[e] <= '1;
        end else if (en) begin
          rc_q[e]  <= rc_d;
          npc_q[e] <= npc_d;
          msk_q[e] <= msk_d;
        end
      end
    end else begin : g_upper
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rc_q[e]  <= '0;
          npc_q[e] <= '0;
          msk_q[e] <= '0;
        end else if (en) begin
          rc_q[e]  <= rc_d;
          npc_q[e] <= npc_d;
          msk_q[e] <= msk_d;
        end
      end
    end
  end

  assign rd_rc   = rc_q[rd_idx];
  assign rd_npc  = npc_q[rd_idx];
  assign rd_mask = msk_q[rd_idx];
endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
  import simt_stack_pkg::*;
#(
  parameter int              THREADS  = 32,
  parameter int              DEPTH    = 8,
  parameter int              PC_W     = 32,
  parameter logic [PC_W-1:0] START_PC = '0,
  localparam int             SP_W     = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               br_valid,
  input  logic [THREADS-1:0] br_taken,
  input  logic [PC_W-1:0]    br_target,
  input  logic [PC_W-1:0]    br_fall,
  input  logic [PC_W-1:0]    br_reconv,
  input  logic               adv_valid,
  input  logic [PC_W-1:0]    adv_pc,
  output logic [PC_W-1:0]    cur_pc,
  output logic [THREADS-1:0] cur_mask,
  output logic [SP_W-1:0]    depth,
  output logic               overflow
);
  localparam int WW = SP_W + 2;
  localparam logic [WW-1:0] TOP_IDX = WW'(DEPTH - 1);

  logic [SP_W-1:0]    sp_q, sp_d;
  logic               ovf_q, ovf_d;
  logic [PC_W-1:0]    top_rc, top_npc;
  logic [THREADS-1:0] top_mask;

  stk_op_e            op;
  logic [PC_W-1:0]    new_pc;
  logic [THREADS-1:0] taken_mask, fall_mask;
  logic               push_fall, push_taken;

  logic [2:0]                we;
  logic [2:0][SP_W-1:0]      wa;
  logic [2:0][PC_W-1:0]      w_rc, w_npc;
  logic [2:0][THREADS-1:0]   w_mask;

  logic               at_bottom, merge, upd;
  logic [WW-1:0]      base_w, slot1_w, slot2_w, end_w;

  simt_branch_classify #(.THREADS(THREADS), .PC_W(PC_W)) u_cls (
    .br_valid  (br_valid),
    .br_taken  (br_taken),
    .br_target (br_target),
    .br_fall   (br_fall),
    .br_reconv (br_reconv),
    .adv_valid (adv_valid),
    .adv_pc    (adv_pc),
    .top_mask  (top_mask),
    .op        (op),
    .new_pc    (new_pc),
    .taken_mask(taken_mask),
    .fall_mask (fall_mask),
    .push_fall (push_fall),
    .push_taken(push_taken)
  );

  simt_stack_store #(
    .THREADS(THREADS), .PC_W(PC_W), .DEPTH(DEPTH), .START_PC(START_PC)
  ) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (sp_q),
    .rd_rc  (top_rc),
    .rd_npc (top_npc),
    .rd_mask(top_mask),
    .we     (we),
    .wa     (wa),
    .w_rc   (w_rc),
    .w_npc  (w_npc),
    .w_mask (w_mask)
  );

  // next-state
  always_comb begin
    we        = '0;
    wa        = '0;
    w_rc      = '0;
    w_npc     = '0;
    w_mask    = '0;
    sp_d      = sp_q;
    ovf_d     = ovf_q;
    at_bottom = (sp_q == '0);
    merge     = (br_reconv == top_rc) && !at_bottom;
    base_w    = merge ? WW'(sp_q) - WW'(1) : WW'(sp_q);
    slot1_w   = base_w + WW'(1);
    slot2_w   = slot1_w + WW'(push_fall);
    end_w     = base_w + WW'(push_fall) + WW'(push_taken);
    upd       = (op != OP_IDLE);

    unique case (op)
      OP_ADV, OP_UNIFORM: begin
        if ((new_pc == top_rc) && !at_bottom) begin
          sp_d = sp_q - 1'b1;
        end else begin
          we[0]     = 1'b1;
          wa[0]     = sp_q;
          w_rc[0]   = top_rc;
          w_npc[0]  = new_pc;
          w_mask[0] = top_mask;
        end
      end
      OP_SPLIT: begin
        if (end_w > TOP_IDX) begin
          ovf_d = 1'b1;
        end else begin
          if (!merge) begin
            we[0]     = 1'b1;
            wa[0]     = sp_q;
            w_rc[0]   = top_rc;
            w_npc[0]  = br_reconv;
            w_mask[0] = top_mask;
          end
          if (push_fall) begin
            we[1]     = 1'b1;
            wa[1]     = slot1_w[SP_W-1:0];
            w_rc[1]   = br_reconv;
            w_npc[1]  = br_fall;
            w_mask[1] = fall_mask;
          end
          if (push_taken) begin
            we[2]     = 1'b1;
            wa[2]     = slot2_w[SP_W-1:0];
            w_rc[2]   = br_reconv;
            w_npc[2]  = br_target;
            w_mask[2] = taken_mask;
          end
          sp_d = end_w[SP_W-1:0];
        end
      end
      default: ;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q  <= '0;
      ovf_q <= 1'b0;
    end else if (upd) begin
      sp_q  <= sp_d;
      ovf_q <= ovf_d;
    end
  end

  assign cur_pc   = top_npc;
  assign cur_mask = top_mask;
  assign depth    = sp_q;
  assign overflow = ovf_q;
endmodule

// File: rtl/simt_reconv_stack_chk.sv
module simt_reconv_stack_chk #(
  parameter int THREADS = 32,
  parameter int PC_W    = 32,
  parameter int SP_W    = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               br_valid,
  input logic               adv_valid,
  input logic [PC_W-1:0]    cur_pc,
  input logic [THREADS-1:0] cur_mask,
  input logic [SP_W-1:0]    depth,
  input logic               overflow
);
  assert_mask_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cur_mask != '0);

  assert_bottom_full_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (depth == '0) |-> (cur_mask == '1));

  assert_overflow_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  assert_overflow_no_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> ($stable(depth) && $stable(cur_pc) && $stable(cur_mask)));

  assert_idle_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_valid && !adv_valid) |=> ($stable(cur_pc) && $stable(cur_mask) && $stable(depth)));

  assert_push_narrows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (depth > $past(depth)) |-> ((cur_mask & ~$past(cur_mask)) == '0));
endmodule

bind simt_reconv_stack simt_reconv_stack_chk #(
  .THREADS(THREADS), .PC_W(PC_W), .SP_W(SP_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .br_valid (br_valid),
  .adv_valid(adv_valid),
  .cur_pc   (cur_pc),
  .cur_mask (cur_mask),
  .depth    (depth),
  .overflow (overflow)
);

// File: tb/simt_reconv_stack_test.sv
module simt_reconv_stack_test;
  localparam int         TH    = 4;
  localparam int         DP    = 4;
  localparam int         PW    = 8;
  localparam logic [7:0] SPC   = 8'h10;
  localparam int         SW    = $clog2(DP);
  localparam time        CLK_T = 20ns;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          br_valid, adv_valid;
  logic [TH-1:0] br_taken;
  logic [PW-1:0] br_target, br_fall, br_reconv, adv_pc;
  logic [PW-1:0] cur_pc;
  logic [TH-1:0] cur_mask;
  logic [SW-1:0] depth;
  logic          overflow;

  int compared = 0;
  int mismatched = 0;

  typedef struct { logic [7:0] rc; logic [7:0] npc; logic [3:0] m; } ent_t;
  ent_t stk[$];
  bit   m_ovf;

  always #(CLK_T/2) clk = ~clk;

  simt_reconv_stack #(.THREADS(TH), .DEPTH(DP), .PC_W(PW), .START_PC(SPC)) uut (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_taken(br_taken),
    .br_target(br_target), .br_fall(br_fall), .br_reconv(br_reconv),
    .adv_valid(adv_valid), .adv_pc(adv_pc), .cur_pc(cur_pc),
    .cur_mask(cur_mask), .depth(depth), .overflow(overflow)
  );

  function automatic string set_pc(logic [7:0] pc, string dflt);
    ent_t t = stk[stk.size()-1];
    if (stk.size() > 1 && pc == t.rc) begin
      void'(stk.pop_back());
      return (stk[stk.size()-1].rc == t.rc) ? "R5" : "R6";
    end
    t.npc = pc;
    stk[stk.size()-1] = t;
    if (stk.size() == 1 && pc == 8'hFF) return "R12";
    return dflt;
  endfunction

  function automatic string model(bit bv, logic [3:0] bm, logic [7:0] tg,
                                  logic [7:0] ft, logic [7:0] rc, bit av,
                                  logic [7:0] ap);
    ent_t  top = stk[stk.size()-1];
    logic [3:0] eff = bm & top.m;
    logic [3:0] oth = top.m & ~eff;
    string tag;
    if (bv) begin
      if (eff == 4'b0 || oth == 4'b0) begin
        tag = set_pc((eff == 4'b0) ? ft : tg, ((bm & ~top.m) != 0) ? "R7" : "R3");
      end else begin
        ent_t add[$];
        bit   mrg = (stk.size() > 1) && (top.rc == rc);
        if (ft != rc) add.push_back('{rc: rc, npc: ft, m: oth});
        if (tg != rc) add.push_back('{rc: rc, npc: tg, m: eff});
        if (stk.size() - int'(mrg) + add.size() > DP) begin
          m_ovf = 1'b1;
          tag = "R11";
        end else begin
          if (mrg) void'(stk.pop_back());
          else begin top.npc = rc; stk[stk.size()-1] = top; end
          foreach (add[i]) stk.push_back(add[i]);
          tag = mrg ? "R10" : (add.size() < 2 ? "R9" : "R4");
        end
      end
      if (av) tag = "R8";
    end else if (av) begin
      tag = set_pc(ap, "R2");
    end else begin
      tag = "R13";
    end
    return tag;
  endfunction

  task automatic compare(string tag);
    ent_t t = stk[stk.size()-1];
    compared++;
    if (cur_pc !== t.npc || cur_mask !== t.m || depth !== SW'(stk.size()-1)
        || overflow !== m_ovf) begin
      mismatched++;
      $display("FAIL %s: pc=%h mask=%b depth=%0d ovf=%b expected pc=%h mask=%b depth=%0d ovf=%b",
               tag, cur_pc, cur_mask, depth, overflow, t.npc, t.m, stk.size()-1, m_ovf);
    end
  endtask

  task automatic cyc(bit bv, logic [3:0] bm, logic [7:0] tg, logic [7:0] ft,
                     logic [7:0] rc, bit av, logic [7:0] ap);
    string tag;
    br_valid = bv; br_taken = bm; br_target = tg; br_fall = ft; br_reconv = rc;
    adv_valid = av; adv_pc = ap;
    @(posedge clk);
    @(negedge clk);
    tag = model(bv, bm, tg, ft, rc, av, ap);
    compare(tag);
  endtask

  initial begin
    #(CLK_T * 200000);
    mismatched++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    br_valid = 0; adv_valid = 0; br_taken = '0;
    br_target = '0; br_fall = '0; br_reconv = '0; adv_pc = '0;
    stk.delete();
    stk.push_back('{rc: 8'hFF, npc: SPC, m: 4'hF});
    m_ovf = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    cyc(0, 4'h0, 8'h00, 8'h00, 8'h00, 0, 8'h00);    // R13 idle
    cyc(0, 4'h0, 8'h00, 8'h00, 8'h00, 1, 8'h11);    // R2 advance
    cyc(1, 4'hF, 8'h20, 8'h2F, 8'h2E, 0, 8'h00);    // R3 all taken
    cyc(1, 4'h0, 8'h2A, 8'h21, 8'h2E, 0, 8'h00);    // R3 none taken
    cyc(1, 4'h7, 8'h30, 8'h40, 8'h50, 0, 8'h00);    // R4 split
    cyc(1, 4'h0, 8'h33, 8'h32, 8'h50, 1, 8'h99);    // R8 branch wins
    cyc(0, 4'h0, 8'h00, 8'h00, 8'h00, 1, 8'h50);    // R5 pop to sibling
    cyc(1, 4'hF, 8'h45, 8'h46, 8'h50, 0, 8'h00);    // R7 inactive bits
    cyc(0, 4'h0, 8'h00, 8'h00, 8'h00, 1, 8'h50);    // R6 rejoin
    cyc(1, 4'h3, 8'h60, 8'h70, 8'h60, 0, 8'h00);    // R9 empty path
    cyc(1, 4'h4, 8'h71, 8'h72, 8'h60, 0, 8'h00);    // R10 merge
    cyc(0, 4'h0, 8'h00, 8'h00, 8'h00, 1, 8'h60);    // R5
    cyc(0, 4'h0, 8'h00, 8'h00, 8'h00, 1, 8'h60);    // R6
    cyc(1, 4'h3, 8'h80, 8'h90, 8'hA0, 0, 8'h00);    // R4
    cyc(1, 4'h1, 8'h81, 8'h82, 8'h85, 0, 8'h00);    // R11 overflow
    cyc(0, 4'h0, 8'h00, 8'h00, 8'h00, 1, 8'hA0);    // R5
    cyc(0, 4'h0, 8'h00, 8'h00, 8'h00, 1, 8'hA0);    // R6
    cyc(0, 4'h0, 8'h00, 8'h00, 8'h00, 1, 8'hFF);    // R12 bottom stays

    for (int i = 0; i < 4000; i++) begin
      int k = $urandom_range(0, 9);
      cyc(k < 5, 4'($urandom_range(0, 15)),
          8'($urandom_range(32, 39)), 8'($urandom_range(32, 39)),
          8'($urandom_range(32, 39)), k >= 3 && k < 9,
          8'($urandom_range(32, 39)));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule